// File: doc/BRIEF.md
# Control Signal Phase Alignment Stage

This block sits behind a sequencing decode array whose product terms are only meaningful in the first phase of each machine cycle; during the second phase the array is precharging and its outputs are garbage. The stage qualifies each raw term with the phase, merges optional term pairs, and turns every logical control into a pulse two phases wide. Each control has a delay class fixed at build time: it starts in the same half-cycle, one half-cycle later, or a full cycle later. A register-write style control can be trimmed so that only its first-phase half survives. Each aligned control can be driven true, inverted, or both.

The two-phase clock is modelled as one clock, with a phase input marking which half-cycle is phase 1. Every clock edge is one half-cycle, and every register stands for one half-cycle of delay. Two controls are also sent to pad drivers. The fetch-marker control reaches its pad one further half-cycle later, so that it lands in the cycle that overlaps the last execute cycle. The write control reaches the read/write pad a full cycle later and inverted, so that the pad is low during a write.

Top module: `phase_align_stage`

## Requirements
- R1: A synchronous reset clears every pipeline register. In the half-cycle after a reset edge `syncPad` is 0 and `rwPad` is 1. Controls of classes 1 and 2 are inactive (`ctlTrue` bit 0, `ctlInv` bit 1).
- R2: A raw term counts only in a half-cycle with `phaseP1`=1. Raw input seen while `phaseP1`=0 changes no output, now or later.
- R3: Output i takes its class from `CLASS_TBL[2i+1:2i]`. Class 2'b00 makes the aligned control high in the half-cycle of the raw term and in the following one.
- R4: Class 2'b01 makes the aligned control high in the two half-cycles after the raw term's half-cycle, that is phase 2 and then the next phase 1.
- R5: Class 2'b10 makes the aligned control high two and three half-cycles after the raw term (the next cycle's phase 1 and phase 2). Code 2'b11 acts the same as 2'b10.
- R6: When `PAIR_EN[i]` is 1, the control is driven by `rawA[i] | rawB[i]`, merged before alignment. Otherwise `rawB[i]` has no effect.
- R7: When `P1_ONLY[i]` is 1, the aligned control is forced low in every half-cycle with `phaseP1`=0.
- R8: `ctlTrue[i]` equals the aligned control when `POL_TRUE[i]` is 1 and is 0 otherwise. `ctlInv[i]` is the inverse of the aligned control when `POL_INV[i]` is 1 and is 1 otherwise.
- R9: `syncPad` equals aligned control `SYNC_IDX` delayed by one half-cycle.
- R10: `rwPad` equals the inverse of aligned control `WR_IDX` delayed by two half-cycles, so that it is low during a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cycle clock; one rising edge per clock phase |
| rst | input | 1 | Synchronous reset, active high |
| phaseP1 | input | 1 | 1 while the current half-cycle is phase 1 |
| rawA | input | N_CTL | Primary raw decode term for each control |
| rawB | input | N_CTL | Second raw term, merged where PAIR_EN is set |
| ctlTrue | output | N_CTL | Aligned controls, true polarity |
| ctlInv | output | N_CTL | Aligned controls, inverted polarity |
| syncPad | output | 1 | Fetch-marker pad drive |
| rwPad | output | 1 | Read/write pad drive, low for write |

## Verification
The checker assumes that `phaseP1` alternates on every clock edge and that reset lasts at least two edges. Its rules on rising edges, such as class-1 controls rising only in phase 2, rest on that strict alternation. The stimulus toggles the phase on every half-cycle without exception, including during reset, and holds each reset for two or more half-cycles. Raw terms are random in both phases, so the phase qualification is tested rather than assumed.

// File: rtl/phalign_pkg.sv
package phalign_pkg;

  typedef enum logic [1:0] {
    DLY_NONE = 2'b00,
    DLY_HALF = 2'b01,
    DLY_FULL = 2'b10
  } delayClass_e;

  typedef struct packed {
    logic rawValid;
    logic keepP1;
  } phaseStrobes_t;

endpackage

// File: rtl/phalign_ctrl.sv
module phalign_ctrl
  import phalign_pkg::*;
(
  input  logic          phaseP1,
  output phaseStrobes_t strobes
);
  // Raw array outputs are valid only in phase 1; phase-1-only
  // controls keep their value only in phase 1 as well.
  always_comb begin
    strobes.rawValid = phaseP1;
    strobes.keepP1   = phaseP1;
  end
endmodule

// File: rtl/phalign_datapath.sv
module phalign_datapath
  import phalign_pkg::*;
#(
  parameter int unsigned N_CTL = 8,
  parameter logic [2*N_CTL-1:0] CLASS_TBL = '0,
  parameter logic [N_CTL-1:0] PAIR_EN  = '0,
  parameter logic [N_CTL-1:0] P1_ONLY  = '0,
  parameter logic [N_CTL-1:0] POL_TRUE = '1,
  parameter logic [N_CTL-1:0] POL_INV  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  phaseStrobes_t    strobes,
  input  logic [N_CTL-1:0] rawA,
  input  logic [N_CTL-1:0] rawB,
  output logic [N_CTL-1:0] aligned,
  output logic [N_CTL-1:0] ctlTrue,
  output logic [N_CTL-1:0] ctlInv
);

  logic [N_CTL-1:0] qualRaw;
  logic [N_CTL-1:0] wide;

  // merge pairs before alignment, then qualify with phase 1
  always_comb begin
    qualRaw = (rawA | (rawB & PAIR_EN)) & {N_CTL{strobes.rawValid}};
  end

  for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
    localparam logic [1:0] CLS = CLASS_TBL[2*i +: 2];

    if (CLS == DLY_NONE) begin : g_none
      logic stage1;
      always_ff @(posedge clk) begin
        if (rst) stage1 <= 1'b0;
        else     stage1 <= qualRaw[i];
      end
      assign wide[i] = qualRaw[i] | stage1;
    end else if (CLS == DLY_HALF) begin : g_half
      logic stage1, stage2;
      always_ff @(posedge clk) begin
        if (rst) begin
          stage1 <= 1'b0;
          stage2 <= 1'b0;
        end else begin
          stage1 <= qualRaw[i];
          stage2 <= stage1;
        end
      end
      assign wide[i] = stage1 | stage2;
    end else begin : g_full
      logic stage1, stage2, stage3;
      always_ff @(posedge clk) begin
        if (rst) begin
          stage1 <= 1'b0;
          stage2 <= 1'b0;
          stage3 <= 1'b0;
        end else begin
          stage1 <= qualRaw[i];
          stage2 <= stage1;
          stage3 <= stage2;
        end
      end
      assign wide[i] = stage2 | stage3;
    end

    if (P1_ONLY[i]) begin : g_trim
      assign aligned[i] = wide[i] & strobes.keepP1;
    end else begin : g_keep
      assign aligned[i] = wide[i];
    end

    if (POL_TRUE[i]) begin : g_true
      assign ctlTrue[i] = aligned[i];
    end else begin : g_true_off
      assign ctlTrue[i] = 1'b0;
    end

    if (POL_INV[i]) begin : g_inv
      assign ctlInv[i] = ~aligned[i];
    end else begin : g_inv_off
      assign ctlInv[i] = 1'b1;
    end
  end

endmodule

// File: rtl/phalign_pads.sv
module phalign_pads (
  input  logic clk,
  input  logic rst,
  input  logic syncCtl,
  input  logic writeCtl,
  output logic syncPad,
  output logic rwPad
);
  logic syncDly;
  logic [1:0] writeDly;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncDly  <= 1'b0;
      writeDly <= 2'b00;
    end else begin
      syncDly  <= syncCtl;
      writeDly <= {writeDly[0], writeCtl};
    end
  end

  assign syncPad = syncDly;
  assign rwPad   = ~writeDly[1];
endmodule

// File: rtl/phase_align_stage.sv
module phase_align_stage
  import phalign_pkg::*;
#(
  parameter int unsigned N_CTL = 8,
  parameter logic [2*N_CTL-1:0] CLASS_TBL = 16'h9861,
  parameter logic [N_CTL-1:0] PAIR_EN  = 8'h43,
  parameter logic [N_CTL-1:0] P1_ONLY  = 8'hA4,
  parameter logic [N_CTL-1:0] POL_TRUE = 8'hDF,
  parameter logic [N_CTL-1:0] POL_INV  = 8'h35,
  parameter int unsigned SYNC_IDX = 0,
  parameter int unsigned WR_IDX   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phaseP1,
  input  logic [N_CTL-1:0] rawA,
  input  logic [N_CTL-1:0] rawB,
  output logic [N_CTL-1:0] ctlTrue,
  output logic [N_CTL-1:0] ctlInv,
  output logic             syncPad,
  output logic             rwPad
);

  phaseStrobes_t    strobes;
  logic [N_CTL-1:0] alignedCtl;

  phalign_ctrl ctrl_i (
    .phaseP1 (phaseP1),
    .strobes (strobes)
  );

  phalign_datapath #(
    .N_CTL     (N_CTL),
    .CLASS_TBL (CLASS_TBL),
    .PAIR_EN   (PAIR_EN),
    .P1_ONLY   (P1_ONLY),
    .POL_TRUE  (POL_TRUE),
    .POL_INV   (POL_INV)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .rawA    (rawA),
    .rawB    (rawB),
    .aligned (alignedCtl),
    .ctlTrue (ctlTrue),
    .ctlInv  (ctlInv)
  );

  phalign_pads pads_i (
    .clk      (clk),
    .rst      (rst),
    .syncCtl  (alignedCtl[SYNC_IDX]),
    .writeCtl (alignedCtl[WR_IDX]),
    .syncPad  (syncPad),
    .rwPad    (rwPad)
  );

endmodule

// File: rtl/phalign_checker.sv
module phalign_checker #(
  parameter int unsigned N_CTL = 8,
  parameter logic [2*N_CTL-1:0] CLASS_TBL = '0,
  parameter logic [N_CTL-1:0] P1_ONLY  = '0,
  parameter logic [N_CTL-1:0] POL_TRUE = '1,
  parameter logic [N_CTL-1:0] POL_INV  = '0,
  parameter int unsigned SYNC_IDX = 0,
  parameter int unsigned WR_IDX   = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             phaseP1,
  input logic [N_CTL-1:0] aligned,
  input logic [N_CTL-1:0] ctlTrue,
  input logic [N_CTL-1:0] ctlInv,
  input logic             syncPad,
  input logic             rwPad
);

  // R1: pads idle one edge after reset
  p_pads_idle_r1: assert property (@(posedge clk)
    rst |=> (!syncPad && rwPad));

  // R9: fetch-marker pad lags its control by one half-cycle
  p_sync_lag_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (syncPad == $past(aligned[SYNC_IDX])));

  // R10: read/write pad lags the write control by a full cycle, inverted
  p_rw_lag_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (rwPad == !$past(aligned[WR_IDX], 2)));

  for (genvar i = 0; i < N_CTL; i++) begin : g_bit
    localparam logic [1:0] CLS = CLASS_TBL[2*i +: 2];

    if (P1_ONLY[i]) begin : g_trim
      // R7: trimmed controls are never high in phase 2
      p_trim_phase1_r7: assert property (@(posedge clk) disable iff (rst)
        aligned[i] |-> phaseP1);
    end else if (CLS == 2'b01) begin : g_half
      // R4: half-cycle class starts in phase 2
      p_half_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned[i]) |-> !phaseP1);
    end else if (CLS == 2'b00) begin : g_none
      // R3: undelayed class starts in phase 1
      p_none_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned[i]) |-> phaseP1);
    end else begin : g_full
      // R5: full-cycle class starts in phase 1
      p_full_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned[i]) |-> phaseP1);
    end

    if (POL_TRUE[i] && POL_INV[i]) begin : g_both
      // R8: both polarities present and complementary
      p_pol_pair_r8: assert property (@(posedge clk) disable iff (rst)
        ctlTrue[i] != ctlInv[i]);
    end
  end

endmodule

bind phase_align_stage phalign_checker #(
  .N_CTL     (N_CTL),
  .CLASS_TBL (CLASS_TBL),
  .P1_ONLY   (P1_ONLY),
  .POL_TRUE  (POL_TRUE),
  .POL_INV   (POL_INV),
  .SYNC_IDX  (SYNC_IDX),
  .WR_IDX    (WR_IDX)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .phaseP1 (phaseP1),
  .aligned (alignedCtl),
  .ctlTrue (ctlTrue),
  .ctlInv  (ctlInv),
  .syncPad (syncPad),
  .rwPad   (rwPad)
);

// File: tb/phase_align_stage_tb.sv
`timescale 1ns/1ps
module phase_align_stage_tb_top;

  localparam int N = 8;
  localparam logic [2*N-1:0] CLS = 16'h9861;
  localparam logic [N-1:0] PAIR = 8'h43;
  localparam logic [N-1:0] P1O  = 8'hA4;
  localparam logic [N-1:0] PT   = 8'hDF;
  localparam logic [N-1:0] PI   = 8'h35;
  localparam int SYNC_I = 0;
  localparam int WR_I   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phaseP1 = 1'b1;
  logic [N-1:0] rawA = '0;
  logic [N-1:0] rawB = '0;
  logic [N-1:0] ctlTrue, ctlInv;
  logic syncPad, rwPad;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  // reference state
  logic ph = 1'b1;
  logic [N-1:0] h1 = '0, h2 = '0, h3 = '0;
  logic [N-1:0] aH1 = '0, aH2 = '0;

  always #4 clk = ~clk;

  phase_align_stage #(
    .N_CTL(N), .CLASS_TBL(CLS), .PAIR_EN(PAIR), .P1_ONLY(P1O),
    .POL_TRUE(PT), .POL_INV(PI), .SYNC_IDX(SYNC_I), .WR_IDX(WR_I)
  ) dut_i (
    .clk(clk), .rst(rst), .phaseP1(phaseP1), .rawA(rawA), .rawB(rawB),
    .ctlTrue(ctlTrue), .ctlInv(ctlInv), .syncPad(syncPad), .rwPad(rwPad)
  );

  function automatic logic [N-1:0] expAligned(input logic [N-1:0] q, input logic p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (CLS[2*i +: 2])
        2'b00:   r[i] = q[i] | h1[i];
        2'b01:   r[i] = h1[i] | h2[i];
        default: r[i] = h2[i] | h3[i];
      endcase
      if (P1O[i] && !p) r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic string bitTag(input int i);
    if (P1O[i]) return "R7";
    case (CLS[2*i +: 2])
      2'b00:   return "R3";
      2'b01:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cmpVec(input string what, input logic [N-1:0] act, input logic [N-1:0] exp, input string polTag);
    checks++;
    if (act !== exp) begin
      int b = 0;
      for (int i = N - 1; i >= 0; i--) if (act[i] !== exp[i]) b = i;
      errors++;
      $display("FAIL %s %s/%s %s bit %0d: actual %b expected %b", curTag, bitTag(b), polTag, what, b, act, exp);
    end
  endtask

  task automatic cmpBit(input string what, input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s %s: actual %b expected %b", curTag, tag, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N-1:0] q, e;
    @(posedge clk);
    #1;
    rst = r; phaseP1 = ph; rawA = a; rawB = b;
    #2;
    q = (a | (b & PAIR)) & {N{ph}};
    e = expAligned(q, ph);
    cmpVec("ctlTrue", ctlTrue, e & PT, "R8");
    cmpVec("ctlInv", ctlInv, ~(e & PI), "R8");
    cmpBit("syncPad", "R9", syncPad, aH1[SYNC_I]);
    cmpBit("rwPad", "R10", rwPad, ~aH2[WR_I]);
    if (r) begin
      h1 = '0; h2 = '0; h3 = '0; aH1 = '0; aH2 = '0;
    end else begin
      h3 = h2; h2 = h1; h1 = q; aH2 = aH1; aH1 = e;
    end
    ph = ~ph;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));

    // R1: reset with busy raw inputs, then quiet after release
    curTag = "R1";
    for (int k = 0; k < 4; k++) step(1'b1, $urandom, $urandom);
    for (int k = 0; k < 4; k++) step(1'b0, '0, '0);

    // R3 R4 R5 R7 R8 R9 R10: one phase-1 pulse on every control
    curTag = "R3_R4_R5_pulse";
    if (ph !== 1'b1) step(1'b0, '0, '0);
    step(1'b0, '1, '0);
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0);

    // R2: raw terms in phase 2 only must not show up anywhere
    curTag = "R2_phase2_raw";
    if (ph !== 1'b0) step(1'b0, '0, '0);
    for (int k = 0; k < 4; k++) step(1'b0, ph ? '0 : '1, ph ? '0 : '1);
    for (int k = 0; k < 4; k++) step(1'b0, '0, '0);

    // R6: second term alone, paired and unpaired outputs
    curTag = "R6_pair";
    if (ph !== 1'b1) step(1'b0, '0, '0);
    step(1'b0, '0, '1);
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0);

    // back-to-back cycles keep controls continuous (R4 R5)
    curTag = "R4_R5_back_to_back";
    for (int k = 0; k < 8; k++) step(1'b0, '1, '0);
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0);

    // random mix with occasional reset (R1 .. via model)
    curTag = "R8_random";
    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 200) == 0) begin
        curTag = "R1_midrun";
        step(1'b1, $urandom, $urandom);
        step(1'b1, $urandom, $urandom);
        curTag = "R8_random";
      end else begin
        step(1'b0, $urandom, $urandom);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule